// File: doc/BRIEF.md
# Banked Nibble Control Register File

This block stores the 4-bit control settings that steer a playback chip's downstream logic. Sixteen main registers sit at addresses 0 to F. Three extra shadow banks reuse part of the same address space. The two low bits of register F choose which bank later accesses reach. Register F itself can always be addressed, so the selection can be changed at any time.

A host-side interface (not part of this block) presents a single-cycle write strobe with a 4-bit address and 4-bit data. Reads are combinational and use the same address. Every stored nibble is also driven out on flat parallel buses, so the servo, motor and output-format logic can use the settings directly.

Within a shadow bank, only four addresses hold storage. Writes to any other address in a shadow bank are dropped, and reads of those addresses return zero.

Top module: `creg_bank_top`

## Requirements
- R1: The bank select is bits 1:0 of main register F. Value 00 selects the main registers, 01 selects shadow bank 1, 10 selects shadow bank 2 and 11 selects shadow bank 3. Bits 3:2 of register F are stored and read back, but they do not affect bank selection.
- R2: With the main bank selected, a write to address a updates main register a at the next clock edge. `main_q[4a+3:4a]` then shows the value, and a read of address a returns it combinationally.
- R3: A write to address F always updates main register F, whichever bank is selected. A read of address F always returns main register F.
- R4: In shadow bank b (1 to 3), addresses 3, 7, A and C map to slots 0, 1, 2 and 3. A write updates that slot at the next edge, and the slot appears on `shadow_q[16(b-1)+4s+3 : 16(b-1)+4s]` for slot s. A read of that address in that bank returns the slot.
- R5: While a shadow bank is selected, a write to an address other than 3, 7, A, C or F changes no output.
- R6: While a shadow bank is selected, a read of an address other than 3, 7, A, C or F returns 0000.
- R7: While a shadow bank is selected, a write to any address other than F leaves main registers 0 to E unchanged.
- R8: A synchronous active-high reset sets main register 3 to 1100. It sets every other main register, every shadow slot and the bank select to 0000 / 00.
- R9: Writing register F with its low bits set to 00 returns later accesses to the main registers. Shadow contents are kept, and they are reached again when the same bank is reselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 4 | Register address for writes and reads |
| wdata | input | 4 | Write data nibble |
| rdata | output | 4 | Combinational read data for `addr` |
| main_q | output | 64 | Main registers; register i at bits 4i+3:4i |
| shadow_q | output | 48 | Shadow slots; bank b slot s at bits 16(b-1)+4s+3:16(b-1)+4s |

## Verification
The bench runs every bank value through writes to all sixteen addresses. After each write it compares both output buses and the read-back of every address against a model in the bench. A design that decoded shadow slots with the wrong mapping would place data in a neighbouring slot or bank, and the bus compare catches this. A design that let unimplemented shadow addresses fall through to main storage would corrupt main registers, which breaks the ignored-write and main-frozen checks. A design that gated address F by bank would lock itself into a shadow bank, so every later check would mismatch. Reset is exercised both at start-up and after the registers are filled, which exposes a wrong value for register 3 or shadow state that survives reset.

// File: rtl/creg_bank_pkg.sv
package creg_bank_pkg;

    localparam int NIB_W    = 4;
    localparam int ADDR_W   = 4;
    localparam int N_MAIN   = 16;
    localparam int N_SHADOW = 3;
    localparam int N_SLOT   = 4;
    localparam int SLOT_W   = $clog2(N_SLOT);
    localparam int SEL_ADDR = N_MAIN - 1;
    localparam int MAIN_W   = N_MAIN * NIB_W;
    localparam int BANK_W   = N_SLOT * NIB_W;
    localparam int SHADOW_W = N_SHADOW * BANK_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        BANK_MAIN = 2'b00,
        BANK_SH1  = 2'b01,
        BANK_SH2  = 2'b10,
        BANK_SH3  = 2'b11
    } bank_e;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    // Maps a raw address to a shadow slot; only four addresses are populated.
    function automatic slot_t slot_decode(addr_t a);
        slot_t s;
        s = '0;
        case (a)
            4'h3: begin s.hit = 1'b1; s.idx = 2'd0; end
            4'h7: begin s.hit = 1'b1; s.idx = 2'd1; end
            4'hA: begin s.hit = 1'b1; s.idx = 2'd2; end
            4'hC: begin s.hit = 1'b1; s.idx = 2'd3; end
            default: s = '0;
        endcase
        return s;
    endfunction

    // Reset image of the main file: register 3 selects the default output format.
    function automatic logic [MAIN_W-1:0] main_reset_vec();
        logic [MAIN_W-1:0] v;
        v = '0;
        v[3*NIB_W +: NIB_W] = 4'b1100;
        return v;
    endfunction

endpackage

// File: rtl/creg_decode.sv
module creg_decode
    import creg_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  addr_t                      addr,
    input  bank_e                      bank,
    output logic [N_MAIN-1:0]          main_we,
    output logic [N_SHADOW*N_SLOT-1:0] shadow_we
);

    slot_t slot;
    logic  is_sel;

    assign slot   = slot_decode(addr);
    assign is_sel = (addr == ADDR_W'(SEL_ADDR));

    always_comb begin
        for (int i = 0; i < N_MAIN; i++) begin
            main_we[i] = wr_en && (addr == ADDR_W'(i)) &&
                         (is_sel || bank == BANK_MAIN);
        end
    end

    always_comb begin
        for (int b = 0; b < N_SHADOW; b++) begin
            for (int k = 0; k < N_SLOT; k++) begin
                shadow_we[b*N_SLOT + k] = wr_en && !is_sel && slot.hit &&
                                          (int'(bank) == b + 1) &&
                                          (int'(slot.idx) == k);
            end
        end
    end

    // A write never lands in two places at once (R5, R7).
    assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_we, shadow_we}));

    // Address F is reachable from every bank (R3).
    assert_sel_reach_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_sel) |-> main_we[SEL_ADDR]);

endmodule

// File: rtl/creg_nib_array.sv
module creg_nib_array
    import creg_bank_pkg::*;
#(
    parameter int                     N         = 4,
    parameter logic [N*NIB_W-1:0]     RESET_VEC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       we,
    input  nib_t               wdata,
    output logic [N*NIB_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VEC;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we[i]) q[i*NIB_W +: NIB_W] <= wdata;
            end
        end
    end

    // Reset loads the reset image (R8).
    assert_reset_image_R8: assert property (@(posedge clk)
        rst |=> (q == RESET_VEC));

    // With no strobe the storage holds its contents (R2).
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (we == '0) |=> $stable(q));

endmodule

// File: rtl/creg_bank_top.sv
module creg_bank_top
    import creg_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NIB_W-1:0]    wdata,
    output logic [NIB_W-1:0]    rdata,
    output logic [MAIN_W-1:0]   main_q,
    output logic [SHADOW_W-1:0] shadow_q
);

    bank_e                      bank;
    logic [N_MAIN-1:0]          main_we;
    logic [N_SHADOW*N_SLOT-1:0] shadow_we;
    slot_t                      rd_slot;

    assign bank    = bank_e'(main_q[SEL_ADDR*NIB_W +: 2]);
    assign rd_slot = slot_decode(addr);

    creg_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .bank      (bank),
        .main_we   (main_we),
        .shadow_we (shadow_we)
    );

    creg_nib_array #(
        .N         (N_MAIN),
        .RESET_VEC (main_reset_vec())
    ) u_main (
        .clk   (clk),
        .rst   (rst),
        .we    (main_we),
        .wdata (wdata),
        .q     (main_q)
    );

    for (genvar b = 0; b < N_SHADOW; b++) begin : g_shadow
        creg_nib_array #(
            .N         (N_SLOT),
            .RESET_VEC ('0)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (shadow_we[b*N_SLOT +: N_SLOT]),
            .wdata (wdata),
            .q     (shadow_q[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        int bi;
        bi    = int'(bank) - 1;
        rdata = '0;
        if (addr == ADDR_W'(SEL_ADDR) || bank == BANK_MAIN) begin
            rdata = main_q[int'(addr)*NIB_W +: NIB_W];
        end else if (rd_slot.hit) begin
            rdata = shadow_q[(bi*N_SLOT + int'(rd_slot.idx))*NIB_W +: NIB_W];
        end
    end

    // Writing F lands its data in register F on the next edge (R3, R1).
    assert_sel_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(SEL_ADDR)) |=>
        (main_q[SEL_ADDR*NIB_W +: NIB_W] == $past(wdata)));

    // Shadow-mode writes away from F never disturb the main file (R7).
    assert_main_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bank != BANK_MAIN && addr != ADDR_W'(SEL_ADDR)) |=>
        $stable(main_q));

    // Unpopulated shadow addresses swallow writes (R5).
    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bank != BANK_MAIN && addr != ADDR_W'(SEL_ADDR) &&
         !slot_decode(addr).hit) |=> ($stable(shadow_q) && $stable(main_q)));

    // Unpopulated shadow addresses read as zero (R6).
    assert_unimpl_read_R6: assert property (@(posedge clk) disable iff (rst)
        (bank != BANK_MAIN && addr != ADDR_W'(SEL_ADDR) &&
         !slot_decode(addr).hit) |-> (rdata == '0));

endmodule

// File: tb/sim_creg_bank_top.sv
module sim_creg_bank_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  addr;
    logic [3:0]  wdata;
    logic [3:0]  rdata;
    logic [63:0] main_q;
    logic [47:0] shadow_q;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [3:0] m [16];
    logic [3:0] s [3][4];

    always #2 clk = ~clk;

    creg_bank_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .main_q(main_q), .shadow_q(shadow_q)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int slot_of(logic [3:0] a);
        case (a)
            4'h3: return 0;
            4'h7: return 1;
            4'hA: return 2;
            4'hC: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [63:0] pack_main();
        logic [63:0] v;
        for (int i = 0; i < 16; i++) v[i*4 +: 4] = m[i];
        return v;
    endfunction

    function automatic logic [47:0] pack_shadow();
        logic [47:0] v;
        for (int b = 0; b < 3; b++)
            for (int k = 0; k < 4; k++) v[b*16 + k*4 +: 4] = s[b][k];
        return v;
    endfunction

    function automatic logic [3:0] model_read(logic [3:0] a);
        int bk;
        bk = int'(m[15][1:0]);
        if (a == 4'hF || bk == 0) return m[a];
        if (slot_of(a) >= 0) return s[bk-1][slot_of(a)];
        return 4'h0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m[i] = 4'h0;
        m[3] = 4'b1100;
        for (int b = 0; b < 3; b++)
            for (int k = 0; k < 4; k++) s[b][k] = 4'h0;
    endtask

    task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, capture at posedge, compare at the next negedge.
    task automatic do_write(logic [3:0] a, logic [3:0] d);
        int bk;
        int sl;
        bk = int'(m[15][1:0]);
        sl = slot_of(a);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 4'hF || bk == 0) m[a] = d;
        else if (sl >= 0) s[bk-1][sl] = d;
    endtask

    task automatic check_all(string tag);
        cmp({tag, " main_q"}, main_q, pack_main());
        cmp({tag, " shadow_q"}, {16'h0, shadow_q}, {16'h0, pack_shadow()});
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            #0.5;
            cmp({tag, " rdata"}, {60'h0, rdata}, {60'h0, model_read(4'(a))});
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = 4'h0; wdata = 4'h0;
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check_all("R8 reset");

        // Sweep every bank, every address, with bank-dependent data.
        for (int bk = 0; bk < 4; bk++) begin
            do_write(4'hF, {2'(bk ^ 2), 2'(bk)});
            check_all("R1 select");
            for (int a = 0; a < 15; a++) begin
                logic [3:0] d;
                d = 4'((a * 3 + bk * 5 + 1) & 15);
                do_write(4'(a), d);
                if (bk == 0)              check_all("R2 main write");
                else if (slot_of(4'(a)) >= 0) check_all("R4 shadow write");
                else                      check_all("R5 R6 R7 ignored");
            end
        end

        // F stays reachable from a shadow bank; upper bits do not move the bank.
        do_write(4'hF, 4'b1110);
        check_all("R3 sel from shadow");
        do_write(4'h7, 4'h9);
        check_all("R1 upper bits ignored");

        // Back to main; shadow contents kept and reachable again.
        do_write(4'hF, 4'b0100);
        check_all("R9 return to main");
        do_write(4'h7, 4'h5);
        check_all("R9 main write after return");
        do_write(4'hF, 4'b0001);
        check_all("R9 shadow retained");

        // Reset after the file is populated.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R8 reset after use");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule